// File: doc/BRIEF.md
# Hybrid Cellular Automaton Pattern Generator

This block is a one-dimensional register of cells that produces pseudo-random test patterns. On each enabled clock every cell takes a new value that depends only on itself and its two adjacent cells. Two cell rules alternate along the array. A rule 90 cell takes the XOR of its two neighbours. A rule 150 cell takes the XOR of its two neighbours and its own value. Because every cell reads only local neighbours, adjacent output bits are not shifted copies of one another, as they are in a shift-register generator.

A controller writes a starting value through the seed port and then raises the step input for as many cycles as it needs patterns. The whole register is visible in parallel on the state output. The all-zero pattern never changes under these rules, so a zero seed is replaced by a non-zero default. The cells past both ends of the array count as constant zero. The array length is a parameter and is five by default. A second parameter chooses whether the even-numbered cells or the odd-numbered cells use rule 150.

Top module: `hybrid_ca_gen`

## Requirements
- R1: While rst_n is low, state is forced to DEFAULT_SEED, which is 5'b00001 by default.
- R2: A clock edge with load high and a non-zero seed puts seed into state.
- R3: A clock edge with load high and seed equal to zero puts DEFAULT_SEED into state.
- R4: When load and step are both high, the load takes priority and no update step is applied.
- R5: When load and step are both low, state keeps its value across the clock edge.
- R6: With the default configuration, bit i of state is cell i. The cells at even positions (0, 2, 4) use rule 150: next value = cell i-1 XOR cell i XOR cell i+1, applied when step is high and load is low.
- R7: With the default configuration, the cells at odd positions (1, 3) use rule 90: next value = cell i-1 XOR cell i+1.
- R8: The neighbour below cell 0 and the neighbour above cell WIDTH-1 are constant zero.
- R9: With the default configuration the update is invertible, so a non-zero state never steps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Writes seed into the cells |
| seed | input | WIDTH | Start value; zero selects DEFAULT_SEED |
| step | input | 1 | Advances the automaton by one generation |
| state | output | WIDTH | Current value of all cells |

## Verification
A single-bit seed at the low end and another at the high end show whether the zero boundaries are applied correctly at each edge, or whether values wrap around or are lost. A mixed seed followed by a run of more than a hundred generations checks every cell against a separate model. Any error in the rule of one cell, or in the order of the neighbours, then grows quickly and becomes visible. Cycles with step low, with step and load high together, and with a zero seed tell the hold behaviour, the load priority and the zero replacement apart from ordinary stepping.

// File: rtl/hybrid_ca_gen.sv
module hybrid_ca_gen #(
  parameter int unsigned WIDTH = 5,
  parameter bit EVEN_RULE150 = 1'b1,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  input  logic             step,
  output logic [WIDTH-1:0] state
);

  logic [WIDTH+1:0] padded;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] seed_eff;

  assign padded   = {1'b0, state, 1'b0};
  assign seed_eff = (seed == '0) ? DEFAULT_SEED : seed;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    localparam bit IS_R150 = (((i % 2) == 0) == EVEN_RULE150);
    if (IS_R150) begin : g_r150
      assign nxt[i] = padded[i] ^ padded[i+1] ^ padded[i+2];
    end else begin : g_r90
      assign nxt[i] = padded[i] ^ padded[i+2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= DEFAULT_SEED;
    else if (load) state <= seed_eff;
    else if (step) state <= nxt;
  end

endmodule

module hybrid_ca_gen_props #(
  parameter int unsigned WIDTH = 5,
  parameter bit EVEN_RULE150 = 1'b1,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic [WIDTH-1:0] seed,
  input logic             step,
  input logic [WIDTH-1:0] state
);

  a_r1_reset_value: assert property (@(posedge clk) !rst_n |=> state == DEFAULT_SEED);

  a_r2_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seed != '0) |=> state == $past(seed));

  a_r3_zero_seed: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seed == '0) |=> state == DEFAULT_SEED);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(state));

  a_r8_low_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> state[0] == ($past(state[1]) ^ (EVEN_RULE150 ? $past(state[0]) : 1'b0)));

  a_r9_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && state != '0 && WIDTH == 5 && EVEN_RULE150) |=> state != '0);

endmodule

bind hybrid_ca_gen hybrid_ca_gen_props #(
  .WIDTH(WIDTH), .EVEN_RULE150(EVEN_RULE150), .DEFAULT_SEED(DEFAULT_SEED)
) u_props (
  .clk(clk), .rst_n(rst_n), .load(load), .seed(seed), .step(step), .state(state)
);

// File: tb/hybrid_ca_gen_test.sv
`timescale 1ns/1ps
module hybrid_ca_gen_test;
  localparam int W = 5;
  localparam logic [W-1:0] DEF = 5'b00001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic step = 1'b0;
  logic [W-1:0] seed = '0;
  logic [W-1:0] state;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] model;
  logic [W-1:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  hybrid_ca_gen uut (.clk(clk), .rst_n(rst_n), .load(load), .seed(seed), .step(step), .state(state));

  function automatic logic [W-1:0] gen(input logic [W-1:0] s);
    logic [W-1:0] n;
    for (int i = 0; i < W; i++) begin
      logic l, r;
      l = (i > 0) ? s[i-1] : 1'b0;
      r = (i < W-1) ? s[i+1] : 1'b0;
      n[i] = (i % 2 == 0) ? (l ^ s[i] ^ r) : (l ^ r);
    end
    return n;
  endfunction

  task automatic cycle(input logic ld, input logic [W-1:0] sd, input logic st, input string tag);
    @(negedge clk);
    load = ld; seed = sd; step = st;
    if (ld) model = (sd == '0) ? DEF : sd;
    else if (st) model = gen(model);
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (state !== e) begin
          fails++;
          $display("FAIL %s: state=%b expected=%b", t, state, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model = DEF;
    repeat (3) @(negedge clk);
    checks++;
    if (state !== DEF) begin
      fails++;
      $display("FAIL R1: state=%b expected=%b", state, DEF);
    end
    rst_n = 1'b1;
    cycle(0, '0, 0, "R1 R5 hold after reset");
    cycle(1, 5'b10110, 0, "R2 load");
    for (int k = 0; k < 6; k++) cycle(0, '0, 1, "R6 R7 step");
    cycle(0, 5'b11111, 0, "R5 hold");
    cycle(0, '0, 0, "R5 hold");
    cycle(1, '0, 0, "R3 zero seed");
    cycle(1, '0, 1, "R3 R4 zero seed with step");
    cycle(1, 5'b01101, 1, "R4 load priority");
    cycle(1, 5'b00001, 0, "R8 low edge seed");
    cycle(0, '0, 1, "R8 low edge");
    cycle(0, '0, 1, "R8 low edge");
    cycle(1, 5'b10000, 0, "R8 high edge seed");
    cycle(0, '0, 1, "R8 high edge");
    cycle(0, '0, 1, "R8 high edge");
    cycle(1, 5'b01010, 0, "R7 odd seed");
    cycle(0, '0, 1, "R7 odd cells");
    cycle(1, 5'b10101, 0, "R6 even seed");
    cycle(0, '0, 1, "R6 even cells");
    cycle(1, 5'b11001, 0, "R2 load");
    for (int k = 0; k < 120; k++) begin
      cycle(0, '0, 1, "R6 R7 R9 long run");
      if (model == '0) begin
        fails++;
        $display("FAIL R9: model state=%b expected non-zero", model);
      end
    end
    cycle(0, '0, 0, "R5 final hold");
    @(negedge clk);
    load = 0; step = 0;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule